// File: doc/BRIEF.md
# Queue and Configuration Interrupt Router

This block sits between the device core and the interrupt machinery of a paravirtual function. The core raises one-cycle pulses when a virtqueue has used buffers (one pulse input per queue) or when the device-specific configuration has changed. The block turns those pulses into interrupts in one of two modes, chosen by `msix_en`.

With message interrupts off (legacy mode), both kinds of event are merged into an 8-bit cause byte. Any set bit holds a level interrupt line high. A driver read returns the byte and clears it. With message interrupts on, the cause byte is frozen. Each event instead looks up a 16-bit vector register, one per queue plus one for configuration. The block then issues one message request naming that table entry on a valid/ready handshake. A vector holding the reserved no-vector code suppresses the request.

Each source has its own saturating count of waiting events. The next request sits in an output register, so the offered vector never changes while it waits for `req_ready`.

Top module: `intr_route`

## Requirements
- R1: After reset the cause byte is 0x00, `irq_level` is low, `req_valid` is low, and every vector register holds the no-vector code 0xFFFF, so no message request is issued before vectors are programmed.
- R2: In legacy mode (`msix_en`=0), a pulse on any bit of `q_evt` sets bit 0 of the cause byte on the next clock edge. `irq_level` is high whenever any cause bit is set.
- R3: In legacy mode, `cfg_evt` sets bit 1 of the cause byte. Queue and configuration events in the same cycle set both bits together. Bits 7 to 2 always read as zero.
- R4: `status_q` shows the cause byte in the cycle `status_rd` is high. At the following edge the byte clears to zero, and `irq_level` falls with it.
- R5: An event arriving in the same cycle as a clearing read is kept. After that edge its cause bit reads as set.
- R6: In message mode the cause byte is not updated by events and `irq_level` stays low.
- R7: In message mode, a pulse on `q_evt[i]` produces one request whose `req_vector` equals the value last written to vector register i. Registers are written with `vec_wr_en`, `vec_wr_idx` = i and `vec_wr_data`.
- R8: In message mode, `cfg_evt` produces one request carrying the configuration vector, which is written at `vec_wr_idx` = NQ.
- R9: An event whose vector register holds 0xFFFF produces no request, and `req_vector` is never 0xFFFF while `req_valid` is high.
- R10: While `req_valid` is high and `req_ready` is low, the request stays valid with an unchanged `req_vector`.
- R11: Every event produces its own request. Each source holds up to 2^CNT_W-1 waiting events beyond the one in the output register; events past that are dropped.
- R12: When several sources are waiting, the configuration source is served first, then queues in ascending index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msix_en | input | 1 | 1 selects message mode, 0 legacy mode |
| q_evt | input | NQ | Per-queue used-buffer event pulses |
| cfg_evt | input | 1 | Configuration-change event pulse |
| status_rd | input | 1 | Driver read of the cause byte (clears it) |
| status_q | output | 8 | Cause byte: bit 0 queue, bit 1 configuration |
| irq_level | output | 1 | Legacy level interrupt |
| vec_wr_en | input | 1 | Vector register write strobe |
| vec_wr_idx | input | IDX_W | Vector register index: 0..NQ-1 queues, NQ configuration |
| vec_wr_data | input | 16 | Vector value to write |
| req_valid | output | 1 | Message request valid |
| req_ready | input | 1 | Message request accepted |
| req_vector | output | 16 | Table entry for the request |

## Verification
Every cycle, the embedded assertions check several properties. Reserved cause bits stay zero. A read with no coinciding event clears the byte. The byte holds still in message mode, and the level line stays quiet there. A stalled request keeps its vector. A valid request never carries the no-vector code. Only the bench's scenarios can show the rest: that each event maps to the right programmed vector, that repeated events yield that many requests up to the saturation point, and that simultaneous sources are served with configuration first and then queues in ascending order. The bench checks these with a scoreboard of expected vectors.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int VEC_W = 16;
  localparam int ST_W = 8;
  localparam logic [VEC_W-1:0] NO_VECTOR = 16'hFFFF;
  localparam int QBIT = 0;
  localparam int CBIT = 1;
endpackage

// File: rtl/intr_status_byte.sv
module intr_status_byte
  import intr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msix_en,
  input  logic            q_any,
  input  logic            cfg_evt,
  input  logic            status_rd,
  output logic [ST_W-1:0] status_q,
  output logic            irq_level
);

  logic [ST_W-1:0] st_r;
  logic [ST_W-1:0] st_n;
  logic            st_en;

  always_comb begin
    st_n = st_r;
    if (status_rd) begin
      st_n = '0;
    end
    if (!msix_en) begin
      if (q_any) begin
        st_n[QBIT] = 1'b1;
      end
      if (cfg_evt) begin
        st_n[CBIT] = 1'b1;
      end
    end
    st_en = status_rd || (!msix_en && (q_any || cfg_evt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r <= '0;
    end else if (st_en) begin
      st_r <= st_n;
    end
  end

  assign status_q  = st_r;
  assign irq_level = (|st_r) && !msix_en;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[ST_W-1:2] == '0); // R3

  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !(q_any && !msix_en) && !(cfg_evt && !msix_en)) |=> (status_q == '0)); // R4

  AST_MSIX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (msix_en && !status_rd) |=> $stable(status_q)); // R6

  AST_QEVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!msix_en && q_any) |=> status_q[QBIT]); // R5

endmodule

// File: rtl/intr_vector_file.sv
module intr_vector_file
  import intr_pkg::*;
#(
  parameter int NSRC  = 5,
  parameter int IDX_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [VEC_W-1:0]           wr_data,
  output logic [NSRC-1:0][VEC_W-1:0] vec_tbl
);

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_ent
      logic [VEC_W-1:0] ent_r;
      logic             ent_en;

      always_comb begin
        ent_en = wr_en && (wr_idx == IDX_W'(g));
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent_r <= NO_VECTOR;
        end else if (ent_en) begin
          ent_r <= wr_data;
        end
      end

      assign vec_tbl[g] = ent_r;
    end
  endgenerate

endmodule

// File: rtl/intr_pend_arb.sv
module intr_pend_arb
  import intr_pkg::*;
#(
  parameter int NSRC  = 5,
  parameter int CNT_W = 2,
  parameter int IDX_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            hit,
  input  logic [NSRC-1:0][VEC_W-1:0] vec_tbl,
  input  logic                       req_ready,
  output logic                       req_valid,
  output logic [VEC_W-1:0]           req_vector
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  take;
  logic             sel_found;
  logic [IDX_W-1:0] sel;
  logic             load;
  logic             ov_r;
  logic             ov_n;
  logic [VEC_W-1:0] vr_r;
  logic [VEC_W-1:0] vr_n;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_cnt
      logic [CNT_W-1:0] cnt_r;
      logic [CNT_W-1:0] cnt_n;
      logic             cnt_en;

      always_comb begin
        cnt_n  = cnt_r;
        cnt_en = hit[g] || take[g];
        if (hit[g] && !take[g]) begin
          if (cnt_r != CNT_MAX) begin
            cnt_n = cnt_r + 1'b1;
          end
        end else if (take[g] && !hit[g]) begin
          cnt_n = cnt_r - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_r <= '0;
        end else if (cnt_en) begin
          cnt_r <= cnt_n;
        end
      end

      assign pend[g] = (cnt_r != '0);
    end
  endgenerate

  always_comb begin
    sel_found = 1'b0;
    sel       = '0;
    if (pend[NSRC-1]) begin
      sel_found = 1'b1;
      sel       = IDX_W'(NSRC-1);
    end else begin
      for (int i = 0; i < NSRC-1; i++) begin
        if (!sel_found && pend[i]) begin
          sel_found = 1'b1;
          sel       = IDX_W'(i);
        end
      end
    end
  end

  always_comb begin
    load = !ov_r || req_ready;
    take = '0;
    ov_n = ov_r;
    vr_n = vr_r;
    if (load) begin
      ov_n = sel_found && (vec_tbl[sel] != NO_VECTOR);
      vr_n = vec_tbl[sel];
      if (sel_found) begin
        take[sel] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_r <= 1'b0;
      vr_r <= '0;
    end else if (load) begin
      ov_r <= ov_n;
      vr_r <= vr_n;
    end
  end

  assign req_valid  = ov_r;
  assign req_vector = vr_r;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_vector))); // R10

  AST_NO_NOVEC: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_vector != NO_VECTOR)); // R9

  AST_TAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take)); // R12

endmodule

// File: rtl/intr_route.sv
module intr_route
  import intr_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int CNT_W = 2,
  localparam int NSRC  = NQ + 1,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msix_en,
  input  logic [NQ-1:0]     q_evt,
  input  logic              cfg_evt,
  input  logic              status_rd,
  output logic [ST_W-1:0]   status_q,
  output logic              irq_level,
  input  logic              vec_wr_en,
  input  logic [IDX_W-1:0]  vec_wr_idx,
  input  logic [VEC_W-1:0]  vec_wr_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [VEC_W-1:0]  req_vector
);

  logic [NSRC-1:0][VEC_W-1:0] vec_tbl;
  logic [NSRC-1:0]            src_evt;
  logic [NSRC-1:0]            vec_ok;
  logic [NSRC-1:0]            hit;

  always_comb begin
    src_evt = {cfg_evt, q_evt};
    for (int i = 0; i < NSRC; i++) begin
      vec_ok[i] = (vec_tbl[i] != NO_VECTOR);
    end
    hit = msix_en ? (src_evt & vec_ok) : '0;
  end

  intr_status_byte u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .msix_en   (msix_en),
    .q_any     (|q_evt),
    .cfg_evt   (cfg_evt),
    .status_rd (status_rd),
    .status_q  (status_q),
    .irq_level (irq_level)
  );

  intr_vector_file #(
    .NSRC  (NSRC),
    .IDX_W (IDX_W)
  ) u_vecs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (vec_wr_en),
    .wr_idx  (vec_wr_idx),
    .wr_data (vec_wr_data),
    .vec_tbl (vec_tbl)
  );

  intr_pend_arb #(
    .NSRC  (NSRC),
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .vec_tbl    (vec_tbl),
    .req_ready  (req_ready),
    .req_valid  (req_valid),
    .req_vector (req_vector)
  );

  AST_MSIX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    msix_en |-> !irq_level); // R6

  AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!msix_en && (status_q != '0)) |-> irq_level); // R2

endmodule

// File: tb/intr_route_test.sv
module intr_route_test;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;
  localparam int IDX_W = 3;

  logic             clk;
  logic             rst_n;
  logic             msix_en;
  logic [NQ-1:0]    q_evt;
  logic             cfg_evt;
  logic             status_rd;
  logic [7:0]       status_q;
  logic             irq_level;
  logic             vec_wr_en;
  logic [IDX_W-1:0] vec_wr_idx;
  logic [15:0]      vec_wr_data;
  logic             req_valid;
  logic             req_ready;
  logic [15:0]      req_vector;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] exp_vec[$];
  string       exp_tag[$];

  intr_route #(.NQ(NQ), .CNT_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .msix_en(msix_en), .q_evt(q_evt),
    .cfg_evt(cfg_evt), .status_rd(status_rd), .status_q(status_q),
    .irq_level(irq_level), .vec_wr_en(vec_wr_en), .vec_wr_idx(vec_wr_idx),
    .vec_wr_data(vec_wr_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_vector(req_vector)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
      finish_run();
    end
  end

  // Scoreboard monitor: each accepted request is matched against the queue
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (exp_vec.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R9/R11 unexpected request: actual %h expected none", req_vector);
      end else begin
        chk(exp_tag.pop_front(), {16'h0, req_vector}, {16'h0, exp_vec.pop_front()});
      end
    end
  end

  task automatic expect_req(logic [15:0] v, string tag);
    exp_vec.push_back(v);
    exp_tag.push_back(tag);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(logic [NQ-1:0] q, logic c);
    q_evt = q;
    cfg_evt = c;
    tick();
    q_evt = '0;
    cfg_evt = 1'b0;
  endtask

  task automatic wr_vec(int idx, logic [15:0] v);
    vec_wr_en = 1'b1;
    vec_wr_idx = IDX_W'(idx);
    vec_wr_data = v;
    tick();
    vec_wr_en = 1'b0;
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    rst_n = 1'b0; msix_en = 1'b0; q_evt = '0; cfg_evt = 1'b0; status_rd = 1'b0;
    vec_wr_en = 1'b0; vec_wr_idx = '0; vec_wr_data = '0; req_ready = 1'b1;
    drain(3);
    rst_n = 1'b1;
    tick();
    chk("R1 status reset", {24'h0, status_q}, 32'h0);
    chk("R1 irq reset", {31'h0, irq_level}, 32'h0);
    chk("R1 valid reset", {31'h0, req_valid}, 32'h0);

    // Legacy queue event
    pulse(4'b0100, 1'b0);
    chk("R2 queue bit", {24'h0, status_q}, 32'h01);
    chk("R2 irq high", {31'h0, irq_level}, 32'h1);
    pulse('0, 1'b1);
    chk("R3 both bits", {24'h0, status_q}, 32'h03);
    // Clearing read
    status_rd = 1'b1;
    chk("R4 read value", {24'h0, status_q}, 32'h03);
    tick();
    status_rd = 1'b0;
    chk("R4 cleared", {24'h0, status_q}, 32'h0);
    chk("R4 irq low", {31'h0, irq_level}, 32'h0);
    // Simultaneous events only on cfg
    pulse('0, 1'b1);
    chk("R3 cfg only", {24'h0, status_q}, 32'h02);
    // Read with colliding queue event
    status_rd = 1'b1;
    q_evt = 4'b0001;
    tick();
    status_rd = 1'b0;
    q_evt = '0;
    chk("R5 event kept", {24'h0, status_q}, 32'h01);
    status_rd = 1'b1;
    tick();
    status_rd = 1'b0;

    // Message mode before programming: vectors are no-vector
    msix_en = 1'b1;
    pulse(4'b1111, 1'b1);
    drain(4);
    chk("R1 no req unprogrammed", {31'h0, req_valid}, 32'h0);
    chk("R6 status frozen", {24'h0, status_q}, 32'h0);
    chk("R6 irq low", {31'h0, irq_level}, 32'h0);

    wr_vec(0, 16'h0010);
    wr_vec(1, 16'h0011);
    wr_vec(2, 16'h0012);
    wr_vec(NQ, 16'h0020);

    expect_req(16'h0012, "R7 queue2 vector");
    pulse(4'b0100, 1'b0);
    drain(4);
    expect_req(16'h0020, "R8 cfg vector");
    pulse('0, 1'b1);
    drain(4);
    // Queue 3 remains no-vector
    pulse(4'b1000, 1'b0);
    drain(4);
    chk("R9 queue3 suppressed", {31'h0, req_valid}, 32'h0);

    // Ordering under stall
    req_ready = 1'b0;
    pulse(4'b0101, 1'b1);
    drain(3);
    chk("R10 valid held", {31'h0, req_valid}, 32'h1);
    chk("R12 cfg first", {16'h0, req_vector}, 32'h0020);
    drain(2);
    chk("R10 vector stable", {16'h0, req_vector}, 32'h0020);
    expect_req(16'h0020, "R12 order cfg");
    expect_req(16'h0010, "R12 order q0");
    expect_req(16'h0012, "R12 order q2");
    req_ready = 1'b1;
    drain(6);

    // Repeats and saturation on queue 1
    req_ready = 1'b0;
    for (int i = 0; i < 5; i++) pulse(4'b0010, 1'b0);
    for (int i = 0; i < 4; i++) expect_req(16'h0011, "R11 repeat q1");
    drain(2);
    req_ready = 1'b1;
    drain(10);

    // Configuration vector set to no-vector
    wr_vec(NQ, 16'hFFFF);
    pulse('0, 1'b1);
    drain(4);
    chk("R9 cfg suppressed", {31'h0, req_valid}, 32'h0);

    chk("R11 scoreboard empty", exp_vec.size(), 32'h0);
    finish_run();
  end
endmodule